// File: doc/BRIEF.md
# PWM and Edge-Rate Monitor Timer

This block is an 8-bit timer with two personalities chosen by a mode bit. In pulse-width mode it drives a pulse train whose period is fixed at 2^CNT_W-1 prescaled ticks. The output is high for a programmable number of ticks at the start of each period and low for the rest. In capture mode the same counter acts as a watchdog on an external monitor signal. Each active edge on that signal restarts the count. If the edges stop arriving often enough, the count climbs past the compare value and the output is raised.

Software configures the block through a small write port. Address 0 holds the prescaler divisor. Address 1 holds the compare value. Address 2 is the control word. Address 3 is the status register, which clears the sticky overflow flag. The timer output reaches two gated pins, and the overflow flag can raise an interrupt.

Top module: `pgt_top`

## Requirements
- R1: While running, the counter advances once every P+1 system clocks, where P is the value at address 0. The prescaler phase restarts from zero on every start.
- R2: Control word bit positions are: bit0 run, bit1 mode (1 = PWM, 0 = capture), bit2 edge select (0 = rising, 1 = falling), bit3 first-pin enable, bit4 second-pin enable, and bit5 interrupt enable. Writing run = 1 while stopped starts the timer from its initial count, and it keeps running until run is written 0.
- R3: In PWM mode the period is 2^CNT_W-1 ticks. The output is high for the first C ticks of each period and low for the rest, where C is the active compare value. C = 0 gives a constant low and C = 2^CNT_W-1 gives a constant high.
- R4: In PWM mode with the timer stopped, the timer output is 1.
- R5: A compare value written while the timer runs is not used until the next overflow. A start always loads the current compare value.
- R6: Each overflow sets the pending flag. The interrupt line equals the pending flag ANDed with the interrupt enable.
- R7: Writing address 3 with bit0 = 0 clears the pending flag, and writing bit0 = 1 leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R8: In capture mode with the timer stopped, the timer output is 0.
- R9: In capture mode the output rises one clock after the counter first exceeds the compare value, and it returns to 0 on counter overflow.
- R10: In capture mode the monitor input passes through two synchronizer flops. The selected edge restarts the counter, clears the output and reloads the compare value, and the opposite edge has no effect.
- R11: The first pin carries the timer output ANDed with its enable, and only in PWM mode; in capture mode it is 0. The second pin carries the timer output ANDed with its enable in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 prescale, 1 compare, 2 control, 3 status) |
| wrData | input | DATA_W | Write data |
| monIn | input | 1 | External monitor signal for capture mode |
| pinA | output | 1 | First gated output pin (PWM mode only) |
| pinB | output | 1 | Second gated output pin |
| irq | output | 1 | Interrupt request |
| pending | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with CNT_W = 4 and PRE_W = 4. This gives a 15-tick period, so overflows, the deferred compare reload, the collision between an overflow and a software clear, and the capture-mode overflow all occur within a few dozen clocks. The bench uses prescaler divisors of 0, 1 and 2. With these small values it can place cycle-exact samples at the falling edge of the PWM output, at the capture rise one clock after the threshold is crossed, and at the edge reaching the counter three clocks after a pin change.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  // register addresses on the write port
  localparam logic [1:0] ADDR_PRE  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // control word bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_PWM  = 1;
  localparam int CB_FALL = 2;
  localparam int CB_EN0  = 3;
  localparam int CB_EN1  = 4;
  localparam int CB_IE   = 5;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic start;
    logic tick;
    logic edgeHit;
    logic run;
    logic pwmMode;
  } dpCtrl_t;

endpackage

// File: rtl/pgt_prescale.sv
module pgt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             enable,
  input  logic [PRE_W-1:0] divVal,
  output logic             tick
);

  logic [PRE_W-1:0] preCnt;
  logic             wrapNow;

  assign wrapNow = (preCnt >= divVal);
  assign tick    = enable && !restart && wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (restart || !enable || wrapNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // after a tick the next one needs at least divVal+1 clocks unless divVal is 0
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (!tick || divVal == '0)); // R1

endmodule

// File: rtl/pgt_edge.sv
module pgt_edge (
  input  logic clk,
  input  logic rstN,
  input  logic monIn,
  input  logic fallSel,
  output logic edgeHit
);

  logic syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= monIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign edgeHit = fallSel ? (prevB && !syncB) : (syncB && !prevB);

  // an edge pulse never lasts two cycles while the selection holds
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit && $stable(fallSel)) |=> (!edgeHit || !$stable(fallSel))); // R10

endmodule

// File: rtl/pgt_ctrl.sv
module pgt_ctrl
  import pgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              monIn,
  input  logic              ovf,
  output dpCtrl_t           ctl,
  output logic [CNT_W-1:0]  cmpReg,
  output logic              en0,
  output logic              en1,
  output logic              pending,
  output logic              irq
);

  logic [PRE_W-1:0] preVal;
  logic runQ, pwmQ, fallQ, ieQ, pendQ;
  logic ctlWr, statWr, startStb;
  logic tick, edgeHit;
  logic unusedWr;

  assign unusedWr = ^wrData;
  assign ctlWr    = wrEn && (wrAddr == ADDR_CTL);
  assign statWr   = wrEn && (wrAddr == ADDR_STAT);
  assign startStb = ctlWr && wrData[CB_RUN] && !runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preVal <= '0;
      cmpReg <= '0;
      runQ   <= 1'b0;
      pwmQ   <= 1'b0;
      fallQ  <= 1'b0;
      en0    <= 1'b0;
      en1    <= 1'b0;
      ieQ    <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_PRE) preVal <= wrData[PRE_W-1:0];
      if (wrAddr == ADDR_CMP) cmpReg <= wrData[CNT_W-1:0];
      if (ctlWr) begin
        runQ  <= wrData[CB_RUN];
        pwmQ  <= wrData[CB_PWM];
        fallQ <= wrData[CB_FALL];
        en0   <= wrData[CB_EN0];
        en1   <= wrData[CB_EN1];
        ieQ   <= wrData[CB_IE];
      end
    end
  end

  // sticky flag: hardware set beats software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (ovf) begin
      pendQ <= 1'b1;
    end else if (statWr && !wrData[0]) begin
      pendQ <= 1'b0;
    end
  end

  pgt_prescale #(.PRE_W(PRE_W)) uPre (
    .clk     (clk),
    .rstN    (rstN),
    .restart (startStb),
    .enable  (runQ),
    .divVal  (preVal),
    .tick    (tick)
  );

  pgt_edge uEdge (
    .clk     (clk),
    .rstN    (rstN),
    .monIn   (monIn),
    .fallSel (fallQ),
    .edgeHit (edgeHit)
  );

  always_comb begin
    ctl.start   = startStb;
    ctl.tick    = tick;
    ctl.edgeHit = edgeHit;
    ctl.run     = runQ;
    ctl.pwmMode = pwmQ;
  end

  assign pending = pendQ;
  assign irq     = pendQ && ieQ;

  AST_PEND_HW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> pendQ); // R7

  AST_PEND_ONE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrData[0] && !pendQ && !ovf) |=> !pendQ); // R7

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !tick); // R2

endmodule

// File: rtl/pgt_core.sv
module pgt_core
  import pgt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] cmpReg,
  output logic             timerOut,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpAct;
  logic             capOut;
  logic             capEdge;
  logic             atMax;

  assign capEdge = ctl.run && !ctl.pwmMode && ctl.edgeHit;
  assign atMax   = (cnt == CNT_MAX);
  assign ovf     = ctl.run && ctl.tick && atMax && !ctl.start && !capEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= CNT_INIT;
      cmpAct <= '0;
      capOut <= 1'b0;
    end else if (ctl.start) begin
      cnt    <= CNT_INIT;
      cmpAct <= cmpReg;
      capOut <= 1'b0;
    end else if (!ctl.run) begin
      cnt    <= CNT_INIT;
      capOut <= 1'b0;
    end else if (capEdge) begin
      cnt    <= CNT_INIT;
      cmpAct <= cmpReg;
      capOut <= 1'b0;
    end else if (ctl.tick && atMax) begin
      cnt    <= CNT_INIT;
      cmpAct <= cmpReg;
      capOut <= 1'b0;
    end else begin
      if (ctl.tick) cnt <= cnt + 1'b1;
      if (!ctl.pwmMode && (cnt > cmpAct)) capOut <= 1'b1;
    end
  end

  always_comb begin
    if (!ctl.run)          timerOut = ctl.pwmMode;
    else if (ctl.pwmMode)  timerOut = (cnt <= cmpAct);
    else                   timerOut = capOut;
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0); // R3

  AST_IDLE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (cnt == CNT_INIT)); // R2

  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.start && !ovf && !capEdge) |=> $stable(cmpAct)); // R5

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    capEdge |=> !capOut); // R10

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !ctl.pwmMode) |=> !capOut); // R9

endmodule

// File: rtl/pgt_top.sv
module pgt_top
  import pgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              monIn,
  output logic              pinA,
  output logic              pinB,
  output logic              irq,
  output logic              pending
);

  dpCtrl_t          ctl;
  logic [CNT_W-1:0] cmpReg;
  logic             en0, en1;
  logic             timerOut, ovf;

  pgt_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .monIn   (monIn),
    .ovf     (ovf),
    .ctl     (ctl),
    .cmpReg  (cmpReg),
    .en0     (en0),
    .en1     (en1),
    .pending (pending),
    .irq     (irq)
  );

  pgt_core #(.CNT_W(CNT_W)) uCore (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cmpReg   (cmpReg),
    .timerOut (timerOut),
    .ovf      (ovf)
  );

  assign pinA = timerOut && en0 && ctl.pwmMode;
  assign pinB = timerOut && en1;

  AST_PINA_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pwmMode |-> !pinA); // R11

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && en1) |-> (pinB == ctl.pwmMode)); // R4

endmodule

// File: tb/pgt_top_test.sv
`timescale 1ns/1ps
module pgt_top_test;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int PRE_W  = 4;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic monIn = 1'b0;
  logic pinA, pinB, irq, pending;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgt_top #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .monIn(monIn), .pinA(pinA), .pinB(pinB), .irq(irq), .pending(pending)
  );

  function automatic logic [7:0] cw(bit run, bit pwm, bit fall, bit e0, bit e1, bit ie);
    return {2'b00, ie, e1, e0, fall, pwm, run};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R8 reset pinA", pinA, 0);
    check("R8 reset pinB", pinB, 0);
    check("R6 reset pending", pending, 0);
    check("R6 reset irq", irq, 0);
  endtask

  task automatic tIdleLevels();
    wr(2, cw(0, 1, 0, 1, 1, 0));
    @(negedge clk);
    check("R4 pwm idle pinA", pinA, 1);
    check("R4 pwm idle pinB", pinB, 1);
    wr(2, cw(0, 1, 0, 0, 1, 0));
    @(negedge clk);
    check("R11 pinA gated by enable", pinA, 0);
    wr(2, cw(0, 0, 0, 1, 1, 0));
    @(negedge clk);
    check("R8 capture idle pinB", pinB, 0);
    check("R11 capture idle pinA", pinA, 0);
  endtask

  task automatic pwmCase(input int p, input int c);
    int n = MAXV * (p + 1);
    int highs = 0;
    wr(0, 8'(p));
    wr(1, 8'(c));
    wr(2, cw(1, 1, 0, 1, 1, 1));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pinA) highs++;
      if (i == n - 1) check("R6 no pending before overflow", pending, 0);
    end
    @(negedge clk);
    check("R3 R1 high ticks per period", highs, c * (p + 1));
    check("R6 pending after overflow", pending, 1);
    check("R6 irq with enable", irq, 1);
    check("R3 output at period start", pinA, (c > 0) ? 1 : 0);
    wr(2, cw(0, 1, 0, 1, 1, 1));
    @(negedge clk);
    check("R4 pwm output after stop", pinA, 1);
    wr(3, 8'h00);
  endtask

  task automatic tDefer();
    int n = MAXV * 2;
    int h1 = 0;
    int h2 = 0;
    wr(0, 8'd1);
    wr(1, 8'd4);
    wr(2, cw(1, 1, 0, 1, 1, 0));
    for (int i = 0; i < 2 * n; i++) begin
      @(negedge clk);
      if (i == 2) begin wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'd9; end
      if (i == 3) wrEn = 1'b0;
      if (pinA) begin
        if (i < n) h1++; else h2++;
      end
    end
    check("R5 old compare until overflow", h1, 8);
    check("R5 new compare after overflow", h2, 18);
    wr(2, cw(0, 1, 0, 1, 1, 0));
    wr(3, 8'h00);
  endtask

  task automatic tPending();
    wr(0, 8'd0);
    wr(1, 8'd4);
    wr(2, cw(1, 1, 0, 1, 1, 1));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (i == 14) check("R6 pending low before overflow", pending, 0);
      if (i == 15) begin
        check("R6 pending set", pending, 1);
        check("R6 irq set", irq, 1);
      end
      if (i == 20) begin wrEn = 1'b1; wrAddr = 2'd3; wrData = 8'hFE; end
      if (i == 21) begin
        wrEn = 1'b0;
        check("R7 software clear", pending, 0);
      end
      if (i == 29) begin wrEn = 1'b1; wrAddr = 2'd3; wrData = 8'h00; end
      if (i == 30) begin
        wrEn = 1'b0;
        check("R7 hardware set wins", pending, 1);
      end
    end
    wr(2, cw(0, 1, 0, 1, 1, 1));
    wr(3, 8'h01);
    @(negedge clk);
    check("R7 write one keeps set", pending, 1);
    wr(2, cw(0, 1, 0, 1, 1, 0));
    @(negedge clk);
    check("R6 irq masked", irq, 0);
    wr(3, 8'h00);
    @(negedge clk);
    check("R7 clear when idle", pending, 0);
    wr(3, 8'h01);
    @(negedge clk);
    check("R7 write one no set", pending, 0);
  endtask

  task automatic tCapture();
    int aHighs = 0;
    wr(0, 8'd1);
    wr(1, 8'd5);
    wr(2, cw(1, 0, 0, 1, 1, 0));
    for (int i = 0; i < 46; i++) begin
      @(negedge clk);
      if (pinA) aHighs++;
      if (i == 10) check("R9 low before threshold", pinB, 0);
      if (i == 11) check("R9 rise after threshold", pinB, 1);
      if (i == 29) check("R9 high before overflow", pinB, 1);
      if (i == 30) check("R9 cleared by overflow", pinB, 0);
      if (i == 41) check("R9 rises again", pinB, 1);
    end
    check("R11 pinA silent in capture", aHighs, 0);
    wr(2, cw(0, 0, 0, 1, 1, 0));
    wr(3, 8'h00);
  endtask

  task automatic tRisingEdges();
    int bHighs = 0;
    monIn = 1'b0;
    wr(0, 8'd1);
    wr(1, 8'd5);
    wr(2, cw(1, 0, 0, 0, 1, 0));
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i % 3 == 0) monIn = ~monIn;
      if (pinB) bHighs++;
    end
    check("R10 frequent edges keep output low", bHighs, 0);
    for (int i = 0; i < 20; i++) @(negedge clk);
    check("R10 output rises once edges stop", pinB, 1);
    wr(2, cw(0, 0, 0, 0, 1, 0));
    wr(3, 8'h00);
  endtask

  task automatic tFallingSel();
    monIn = 1'b0;
    wr(0, 8'd1);
    wr(1, 8'd5);
    wr(2, cw(1, 0, 1, 0, 1, 0));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 4) monIn = 1'b1;
      if (i == 14) monIn = 1'b0;
      if (i == 10) check("R10 low before threshold", pinB, 0);
      if (i == 11) check("R10 rising edge ignored", pinB, 1);
      if (i == 16) check("R10 high until edge lands", pinB, 1);
      if (i == 17) check("R10 falling edge clears", pinB, 0);
    end
    wr(2, cw(0, 0, 0, 0, 1, 0));
    wr(3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdleLevels();
    pwmCase(2, 5);
    pwmCase(0, 3);
    pwmCase(1, 0);
    pwmCase(0, MAXV);
    tDefer();
    tPending();
    tCapture();
    tRisingEdges();
    tFallingSel();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule